// File: doc/BRIEF.md
# Power-Management Register Block with System-Control Interrupt

This block is the byte-wide register file of a chipset power-management function. It sits behind a 64-byte I/O window and keeps the power-management status, enable and control words, a general-purpose status/enable pair, a stored global status word, a device status word and a few global and device control words. A bridge outside the block splits wider accesses into single bytes. The bridge presents only the six window-offset bits and a write strobe. Reads are combinational on the offset.

Hardware events reach the status words through per-register set inputs. A free-running timer outside the block supplies its count and a one-cycle overflow strobe. Software acknowledges an event by writing a one to its status bit. The block drives a level system-control interrupt while any of four enabled event sources is pending. It also turns a sleep request written to the control word into a one-cycle soft-off or suspend pulse.

Top module: `pm_regfile`

## Requirements
- R1: Multi-byte registers are little-endian. Offset bit 0 picks the byte of a 16-bit register, and offset bits [1:0] pick the byte of a 32-bit register. The timer count is readable at offsets 0x08 (bits 7:0) to 0x0B (bits 31:24).
- R2: After reset, offset 0x01 reads 0x01 because power-button status (bit 8) is set. Every stored register bit other than that one reads zero.
- R3: PM status (0x00–0x01) clears each bit written as one that lies within mask 0x8D31. Bits written as zero are unchanged. A set request on `pm_set_i`, limited to the same mask, wins over a clear in the same cycle.
- R4: PM enable (0x02–0x03) is read/write and stores only the bits of mask 0x0521.
- R5: `sci_o` is high exactly while (PM status AND PM enable) has any of bit 10, 8, 5 or 0 set. It follows every write and every status change in the cycle after the edge that caused it.
- R6: A one-cycle `timer_ovf_i` sets PM status bit 0 at the next clock edge.
- R7: PM control (0x04–0x05) stores the bits of mask 0x3C07. A write to either byte that leaves bit 13 set issues a one-cycle pulse in the cycle after the write edge. The pulse is `soft_off_o` when bits [12:10] equal 0 and `suspend_o` when they equal 1.
- R8: Sleep types 2 to 7, or a control write that leaves bit 13 clear, produce no pulse. The two pulses are never high together.
- R9: GP status (0x0C–0x0D) is write-one-to-clear under mask 0x0F81, with sets from `gp_set_i` under the same mask. GP enable (0x0E–0x0F) is read/write under mask 0x0F01.
- R10: Offset 0x18 reads the following. Bits 2 and 0 come from the stored global status word. Bit 7 is set when GP status is nonzero, bit 6 when PM status is nonzero, bit 5 when `smm_i` is high, and bit 4 when device status is nonzero. Bits 3 and 1 read zero. Offset 0x19 reads the stored upper byte. The stored word is write-one-to-clear under mask 0x0DF7.
- R11: Device status (0x1C–0x1F) is write-one-to-clear under mask 0x3FFF0FFF and always reads with bit 28 set.
- R12: Global enable (0x20–0x21) stores mask 0x8D1F. Global control (0x28–0x2B) stores mask 0x0700FF07. Device control (0x2C–0x2F) stores mask 0x0FFFFFFF.
- R13: Offsets that hold no register (for example 0x06, 0x14, 0x3F) read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 6 | Byte offset inside the 64-byte window |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for `addr_i` |
| timer_val_i | input | 32 | Current timer count |
| timer_ovf_i | input | 1 | One-cycle timer overflow strobe |
| smm_i | input | 1 | System-management mode indication |
| pm_set_i | input | 16 | Event sets into PM status |
| gp_set_i | input | 16 | Event sets into GP status |
| glb_set_i | input | 16 | Event sets into the stored global status |
| dev_set_i | input | 32 | Event sets into device status |
| sci_o | output | 1 | Level system-control interrupt |
| soft_off_o | output | 1 | One-cycle soft power-off request |
| suspend_o | output | 1 | One-cycle suspend-to-RAM request |

## Verification
The assertions check several rules on every cycle. A status-clear write drops its bit, and an overflow strobe raises status bit 0. The interrupt can only change after a write, a set or an overflow. The sleep pulses always follow a control write and never coincide, and the global byte always mirrors `smm_i`. The directed scenarios cover what needs exact values. These are every storage mask, the byte-lane order, the composed global status byte and the reset contents. They also cover set-over-clear priority, the choice among sleep types, and the proof that writes to empty offsets leave the stored registers unchanged.

// File: rtl/pm_regs_pkg.sv
`timescale 1ns/1ps
package pm_regs_pkg;
   // storage and clear masks
   localparam logic [15:0] PM_STS_MASK  = 16'h8D31;
   localparam logic [15:0] PM_STS_RST   = 16'h0100;
   localparam logic [15:0] PM_EN_MASK   = 16'h0521;
   localparam logic [15:0] PM_CTL_MASK  = 16'h3C07;
   localparam logic [15:0] GP_STS_MASK  = 16'h0F81;
   localparam logic [15:0] GP_EN_MASK   = 16'h0F01;
   localparam logic [15:0] GLB_STS_MASK = 16'h0DF7;
   localparam logic [15:0] GLB_EN_MASK  = 16'h8D1F;
   localparam logic [31:0] GLB_CTL_MASK = 32'h0700FF07;
   localparam logic [31:0] DEV_STS_MASK = 32'h3FFF0FFF;
   localparam logic [31:0] DEV_CTL_MASK = 32'h0FFFFFFF;
   localparam logic [31:0] DEV_RD_FORCE = 32'h10000000;

   // window offsets (base of each register)
   localparam logic [5:0] OFS_PM_STS  = 6'h00;
   localparam logic [5:0] OFS_PM_EN   = 6'h02;
   localparam logic [5:0] OFS_PM_CTL  = 6'h04;
   localparam logic [5:0] OFS_TMR     = 6'h08;
   localparam logic [5:0] OFS_GP_STS  = 6'h0C;
   localparam logic [5:0] OFS_GP_EN   = 6'h0E;
   localparam logic [5:0] OFS_GLB_STS = 6'h18;
   localparam logic [5:0] OFS_DEV_STS = 6'h1C;
   localparam logic [5:0] OFS_GLB_EN  = 6'h20;
   localparam logic [5:0] OFS_GLB_CTL = 6'h28;
   localparam logic [5:0] OFS_DEV_CTL = 6'h2C;

   // sleep field layout in the control word
   localparam int SLP_EN_BIT   = 13;
   localparam int SLP_TYPE_LSB = 10;
   localparam int SLP_TYPE_W   = 3;

   function automatic logic [1:0] lanes16(input logic [5:0] off,
                                          input logic [5:0] base,
                                          input logic we);
      return (we && off[5:1] == base[5:1]) ? (2'b01 << off[0]) : 2'b00;
   endfunction

   function automatic logic [3:0] lanes32(input logic [5:0] off,
                                          input logic [5:0] base,
                                          input logic we);
      return (we && off[5:2] == base[5:2]) ? (4'b0001 << off[1:0]) : 4'b0000;
   endfunction
endpackage

// File: rtl/pm_mreg.sv
`timescale 1ns/1ps
module pm_mreg #(
   parameter int                     BYTES = 2,
   parameter logic [8*BYTES-1:0]     MASK  = '1,
   parameter logic [8*BYTES-1:0]     RST   = '0,
   parameter bit                     W1C   = 1'b0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [BYTES-1:0]     lane_we_i,
   input  logic [7:0]           wdata_i,
   input  logic [8*BYTES-1:0]   set_i,
   output logic [8*BYTES-1:0]   q_o
);
   localparam int W = 8 * BYTES;

   if (BYTES < 1 || BYTES > 4) begin : g_bad_bytes
      $error("pm_mreg: BYTES must be 1..4");
   end
   if ((RST & ~MASK) != '0) begin : g_bad_rst
      $error("pm_mreg: reset value outside mask");
   end

   logic [W-1:0] nxt;

   if (W1C) begin : g_w1c
      logic [W-1:0] clr;
      always_comb begin
         for (int b = 0; b < BYTES; b++)
            clr[8*b +: 8] = lane_we_i[b] ? wdata_i : 8'h00;
      end
      // set wins over a same-cycle clear
      assign nxt = ((q_o & ~clr) | set_i) & MASK;
   end else begin : g_rw
      logic [W-1:0] merged;
      always_comb begin
         for (int b = 0; b < BYTES; b++)
            merged[8*b +: 8] = lane_we_i[b] ? wdata_i : q_o[8*b +: 8];
      end
      assign nxt = (merged | set_i) & MASK;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) q_o <= RST;
      else         q_o <= nxt;
   end
endmodule

// File: rtl/pm_sleep_dec.sv
`timescale 1ns/1ps
module pm_sleep_dec #(
   parameter int EN_BIT   = 13,
   parameter int TYPE_LSB = 10,
   parameter int TYPE_W   = 3,
   parameter int CTL_W    = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ctl_wr_i,
   input  logic [CTL_W-1:0] ctl_q_i,
   output logic             soft_off_o,
   output logic             suspend_o
);
   if (EN_BIT >= CTL_W || TYPE_LSB + TYPE_W > CTL_W) begin : g_bad_field
      $error("pm_sleep_dec: sleep field outside control word");
   end

   logic              wr_d;
   logic              armed;
   logic [TYPE_W-1:0] slp_type;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) wr_d <= 1'b0;
      else         wr_d <= ctl_wr_i;
   end

   assign slp_type   = ctl_q_i[TYPE_LSB +: TYPE_W];
   assign armed      = wr_d && ctl_q_i[EN_BIT];
   assign soft_off_o = armed && (slp_type == TYPE_W'(0));
   assign suspend_o  = armed && (slp_type == TYPE_W'(1));

   // R7
   sleep_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (soft_off_o || suspend_o) |-> $past(ctl_wr_i));
   // R8
   sleep_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(soft_off_o && suspend_o));
endmodule

// File: rtl/pm_regfile.sv
`timescale 1ns/1ps
module pm_regfile
   import pm_regs_pkg::*;
#(
   parameter logic [15:0] SCI_SRC_MASK = 16'h0521
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic [5:0]  addr_i,
   input  logic        wr_en_i,
   input  logic [7:0]  wr_data_i,
   output logic [7:0]  rd_data_o,
   input  logic [31:0] timer_val_i,
   input  logic        timer_ovf_i,
   input  logic        smm_i,
   input  logic [15:0] pm_set_i,
   input  logic [15:0] gp_set_i,
   input  logic [15:0] glb_set_i,
   input  logic [31:0] dev_set_i,
   output logic        sci_o,
   output logic        soft_off_o,
   output logic        suspend_o
);
   if ((SCI_SRC_MASK & ~PM_STS_MASK) != 16'h0) begin : g_bad_sci
      $error("pm_regfile: interrupt source outside status mask");
   end

   logic [15:0] pm_sts_q, pm_en_q, pm_ctl_q, gp_sts_q, gp_en_q, glb_sts_q, glb_en_q;
   logic [31:0] dev_sts_q, glb_ctl_q, dev_ctl_q, dev_rd;
   logic [15:0] pm_set;

   assign pm_set = (pm_set_i | {15'h0, timer_ovf_i}) & PM_STS_MASK;

   pm_mreg #(.BYTES(2), .MASK(PM_STS_MASK), .RST(PM_STS_RST), .W1C(1'b1)) u_pm_sts (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_PM_STS, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(pm_set), .q_o(pm_sts_q));
   pm_mreg #(.BYTES(2), .MASK(PM_EN_MASK), .RST(16'h0), .W1C(1'b0)) u_pm_en (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_PM_EN, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(16'h0), .q_o(pm_en_q));
   pm_mreg #(.BYTES(2), .MASK(PM_CTL_MASK), .RST(16'h0), .W1C(1'b0)) u_pm_ctl (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_PM_CTL, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(16'h0), .q_o(pm_ctl_q));
   pm_mreg #(.BYTES(2), .MASK(GP_STS_MASK), .RST(16'h0), .W1C(1'b1)) u_gp_sts (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_GP_STS, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(gp_set_i & GP_STS_MASK), .q_o(gp_sts_q));
   pm_mreg #(.BYTES(2), .MASK(GP_EN_MASK), .RST(16'h0), .W1C(1'b0)) u_gp_en (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_GP_EN, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(16'h0), .q_o(gp_en_q));
   pm_mreg #(.BYTES(2), .MASK(GLB_STS_MASK), .RST(16'h0), .W1C(1'b1)) u_glb_sts (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_GLB_STS, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(glb_set_i & GLB_STS_MASK), .q_o(glb_sts_q));
   pm_mreg #(.BYTES(4), .MASK(DEV_STS_MASK), .RST(32'h0), .W1C(1'b1)) u_dev_sts (
      .clk_i, .rst_ni, .lane_we_i(lanes32(addr_i, OFS_DEV_STS, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(dev_set_i & DEV_STS_MASK), .q_o(dev_sts_q));
   pm_mreg #(.BYTES(2), .MASK(GLB_EN_MASK), .RST(16'h0), .W1C(1'b0)) u_glb_en (
      .clk_i, .rst_ni, .lane_we_i(lanes16(addr_i, OFS_GLB_EN, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(16'h0), .q_o(glb_en_q));
   pm_mreg #(.BYTES(4), .MASK(GLB_CTL_MASK), .RST(32'h0), .W1C(1'b0)) u_glb_ctl (
      .clk_i, .rst_ni, .lane_we_i(lanes32(addr_i, OFS_GLB_CTL, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(32'h0), .q_o(glb_ctl_q));
   pm_mreg #(.BYTES(4), .MASK(DEV_CTL_MASK), .RST(32'h0), .W1C(1'b0)) u_dev_ctl (
      .clk_i, .rst_ni, .lane_we_i(lanes32(addr_i, OFS_DEV_CTL, wr_en_i)),
      .wdata_i(wr_data_i), .set_i(32'h0), .q_o(dev_ctl_q));

   pm_sleep_dec #(.EN_BIT(SLP_EN_BIT), .TYPE_LSB(SLP_TYPE_LSB), .TYPE_W(SLP_TYPE_W),
                  .CTL_W(16)) u_sleep (
      .clk_i, .rst_ni,
      .ctl_wr_i(lanes16(addr_i, OFS_PM_CTL, wr_en_i) != 2'b00),
      .ctl_q_i(pm_ctl_q), .soft_off_o, .suspend_o);

   // level interrupt from enabled qualifying sources
   assign sci_o = |(pm_sts_q & pm_en_q & SCI_SRC_MASK);

   assign dev_rd = dev_sts_q | DEV_RD_FORCE;

   always_comb begin
      rd_data_o = 8'h00;
      case (addr_i)
         6'h00, 6'h01: rd_data_o = pm_sts_q[{addr_i[0], 3'b000} +: 8];
         6'h02, 6'h03: rd_data_o = pm_en_q[{addr_i[0], 3'b000} +: 8];
         6'h04, 6'h05: rd_data_o = pm_ctl_q[{addr_i[0], 3'b000} +: 8];
         6'h08, 6'h09, 6'h0A, 6'h0B:
                       rd_data_o = timer_val_i[{addr_i[1:0], 3'b000} +: 8];
         6'h0C, 6'h0D: rd_data_o = gp_sts_q[{addr_i[0], 3'b000} +: 8];
         6'h0E, 6'h0F: rd_data_o = gp_en_q[{addr_i[0], 3'b000} +: 8];
         6'h18:        rd_data_o = {(gp_sts_q != 16'h0), (pm_sts_q != 16'h0), smm_i,
                                    (dev_sts_q != 32'h0), 4'h0}
                                   | (glb_sts_q[7:0] & 8'h05);
         6'h19:        rd_data_o = glb_sts_q[15:8];
         6'h1C, 6'h1D, 6'h1E, 6'h1F:
                       rd_data_o = dev_rd[{addr_i[1:0], 3'b000} +: 8];
         6'h20, 6'h21: rd_data_o = glb_en_q[{addr_i[0], 3'b000} +: 8];
         6'h28, 6'h29, 6'h2A, 6'h2B:
                       rd_data_o = glb_ctl_q[{addr_i[1:0], 3'b000} +: 8];
         6'h2C, 6'h2D, 6'h2E, 6'h2F:
                       rd_data_o = dev_ctl_q[{addr_i[1:0], 3'b000} +: 8];
         default:      rd_data_o = 8'h00;
      endcase
   end

   // R3
   pm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == 6'h00 && wr_data_i[0] && !pm_set_i[0] && !timer_ovf_i)
      |=> !pm_sts_q[0]);
   // R6
   ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timer_ovf_i |=> pm_sts_q[0]);
   // R5
   sci_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sci_o) |-> $past(wr_en_i || timer_ovf_i || pm_set_i != 16'h0));
   // R5
   sci_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sci_o) |-> $past(wr_en_i));
   // R10
   glb_smm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == 6'h18) |-> (rd_data_o[5] == smm_i));
endmodule

// File: tb/sim_pm_regfile.sv
`timescale 1ns/1ps
module sim_pm_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        we = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [31:0] tmr = '0;
   logic        ovf = 1'b0;
   logic        smm = 1'b0;
   logic [15:0] pm_set = '0, gp_set = '0, glb_set = '0;
   logic [31:0] dev_set = '0;
   logic        sci, soft_off, suspend;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pm_regfile u0 (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wdata),
      .rd_data_o(rdata), .timer_val_i(tmr), .timer_ovf_i(ovf), .smm_i(smm),
      .pm_set_i(pm_set), .gp_set_i(gp_set), .glb_set_i(glb_set), .dev_set_i(dev_set),
      .sci_o(sci), .soft_off_o(soft_off), .suspend_o(suspend));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; #0.5; d = rdata;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, {24'h0, d}, {24'h0, exp});
   endtask

   task automatic sets(input logic [15:0] p, input logic [15:0] g,
                       input logic [15:0] gl, input logic [31:0] dv);
      @(negedge clk); pm_set = p; gp_set = g; glb_set = gl; dev_set = dv;
      @(negedge clk); pm_set = '0; gp_set = '0; glb_set = '0; dev_set = '0;
   endtask

   task automatic t_reset;
      rd_chk("R2 pm sts lo", 6'h00, 8'h00);
      rd_chk("R2 pm sts hi", 6'h01, 8'h01);
      rd_chk("R2 pm en", 6'h03, 8'h00);
      rd_chk("R2 ctl", 6'h04, 8'h00);
      rd_chk("R2 R11 dev hi", 6'h1F, 8'h10);
      rd_chk("R2 R10 glb", 6'h18, 8'h40);
      chk("R2 sci", {31'h0, sci}, 32'h0);
   endtask

   task automatic t_pm_sts;
      sets(16'hFFFF, 16'h0, 16'h0, 32'h0);
      rd_chk("R3 set lo", 6'h00, 8'h31);
      rd_chk("R3 set hi", 6'h01, 8'h8D);
      wr(6'h00, 8'h00);
      rd_chk("R3 zero write", 6'h00, 8'h31);
      wr(6'h00, 8'h01);
      rd_chk("R3 clear b0", 6'h00, 8'h30);
      wr(6'h01, 8'h01);
      rd_chk("R3 clear b8", 6'h01, 8'h8C);
   endtask

   task automatic t_pm_en;
      wr(6'h02, 8'hFF);
      rd_chk("R4 en lo", 6'h02, 8'h21);
      wr(6'h03, 8'hFF);
      rd_chk("R4 en hi", 6'h03, 8'h05);
      chk("R5 sci with b10 b5", {31'h0, sci}, 32'h1);
   endtask

   task automatic t_sci;
      wr(6'h00, 8'hFF);
      wr(6'h01, 8'hFF);
      chk("R5 sci cleared", {31'h0, sci}, 32'h0);
      sets(16'h8010, 16'h0, 16'h0, 32'h0);
      chk("R5 non-source bits", {31'h0, sci}, 32'h0);
      @(negedge clk); ovf = 1'b1;
      @(negedge clk); ovf = 1'b0;
      chk("R6 R5 sci after overflow", {31'h0, sci}, 32'h1);
      rd_chk("R6 status b0", 6'h00, 8'h11);
      wr(6'h00, 8'h01);
      chk("R5 sci after ack", {31'h0, sci}, 32'h0);
      wr(6'h02, 8'h00);
      sets(16'h0020, 16'h0, 16'h0, 32'h0);
      chk("R5 disabled source", {31'h0, sci}, 32'h0);
      wr(6'h02, 8'h20);
      chk("R5 enable late", {31'h0, sci}, 32'h1);
      wr(6'h00, 8'h20);
      chk("R5 ack b5", {31'h0, sci}, 32'h0);
      // set wins over a same-cycle clear
      @(negedge clk); addr = 6'h00; wdata = 8'h10; we = 1'b1; pm_set = 16'h0010;
      @(negedge clk); we = 1'b0; pm_set = '0;
      rd_chk("R3 set priority", 6'h00, 8'h10);
   endtask

   task automatic t_sleep;
      wr(6'h04, 8'h07);
      chk("R8 no pulse low byte", {30'h0, soft_off, suspend}, 32'h0);
      rd_chk("R7 ctl lo", 6'h04, 8'h07);
      wr(6'h05, 8'hFF);
      chk("R8 type7 no pulse", {30'h0, soft_off, suspend}, 32'h0);
      rd_chk("R7 ctl hi mask", 6'h05, 8'h3C);
      wr(6'h05, 8'h20);
      chk("R7 soft off pulse", {30'h0, soft_off, suspend}, 32'h2);
      @(negedge clk);
      chk("R7 pulse one cycle", {30'h0, soft_off, suspend}, 32'h0);
      wr(6'h05, 8'h24);
      chk("R7 suspend pulse", {30'h0, soft_off, suspend}, 32'h1);
      wr(6'h05, 8'h28);
      chk("R8 type2 no pulse", {30'h0, soft_off, suspend}, 32'h0);
      wr(6'h05, 8'h04);
      chk("R8 no enable no pulse", {30'h0, soft_off, suspend}, 32'h0);
      wr(6'h05, 8'h20);
      wr(6'h04, 8'h00);
      chk("R7 low-byte write with enable", {30'h0, soft_off, suspend}, 32'h2);
   endtask

   task automatic t_timer;
      tmr = 32'hA1B2C3D4;
      rd_chk("R1 tmr b0", 6'h08, 8'hD4);
      rd_chk("R1 tmr b1", 6'h09, 8'hC3);
      rd_chk("R1 tmr b2", 6'h0A, 8'hB2);
      rd_chk("R1 tmr b3", 6'h0B, 8'hA1);
   endtask

   task automatic t_gp;
      sets(16'h0, 16'hFFFF, 16'h0, 32'h0);
      rd_chk("R9 gp sts lo", 6'h0C, 8'h81);
      rd_chk("R9 gp sts hi", 6'h0D, 8'h0F);
      wr(6'h0D, 8'h01);
      rd_chk("R9 gp clear", 6'h0D, 8'h0E);
      wr(6'h0E, 8'hFF);
      rd_chk("R9 gp en lo", 6'h0E, 8'h01);
      wr(6'h0F, 8'hFF);
      rd_chk("R9 gp en hi", 6'h0F, 8'h0F);
   endtask

   task automatic t_glb;
      wr(6'h00, 8'hFF); wr(6'h01, 8'hFF);
      wr(6'h0C, 8'hFF); wr(6'h0D, 8'hFF);
      rd_chk("R10 all clear", 6'h18, 8'h00);
      sets(16'h0, 16'h0, 16'hFFFF, 32'h0);
      rd_chk("R10 stored bits", 6'h18, 8'h05);
      rd_chk("R10 upper byte", 6'h19, 8'h0D);
      smm = 1'b1;
      rd_chk("R10 smm", 6'h18, 8'h25);
      sets(16'h0, 16'h0, 16'h0, 32'h1);
      rd_chk("R10 dev", 6'h18, 8'h35);
      sets(16'h0, 16'h1, 16'h0, 32'h0);
      rd_chk("R10 gp", 6'h18, 8'hB5);
      sets(16'h1, 16'h0, 16'h0, 32'h0);
      rd_chk("R10 pm", 6'h18, 8'hF5);
      wr(6'h18, 8'h04);
      rd_chk("R10 w1c", 6'h18, 8'hF1);
      smm = 1'b0;
   endtask

   task automatic t_dev;
      sets(16'h0, 16'h0, 16'h0, 32'hFFFFFFFF);
      rd_chk("R11 dev b0", 6'h1C, 8'hFF);
      rd_chk("R11 dev b1", 6'h1D, 8'h0F);
      rd_chk("R11 dev b2", 6'h1E, 8'hFF);
      rd_chk("R11 dev b3", 6'h1F, 8'h3F);
      wr(6'h1F, 8'hFF);
      rd_chk("R11 forced b28", 6'h1F, 8'h10);
      wr(6'h20, 8'hFF); rd_chk("R12 glb en lo", 6'h20, 8'h1F);
      wr(6'h21, 8'hFF); rd_chk("R12 glb en hi", 6'h21, 8'h8D);
      wr(6'h28, 8'hFF); rd_chk("R12 glb ctl b0", 6'h28, 8'h07);
      wr(6'h29, 8'hFF); rd_chk("R12 glb ctl b1", 6'h29, 8'hFF);
      wr(6'h2A, 8'hFF); rd_chk("R12 glb ctl b2", 6'h2A, 8'h00);
      wr(6'h2B, 8'hFF); rd_chk("R12 glb ctl b3", 6'h2B, 8'h07);
      wr(6'h2F, 8'hFF); rd_chk("R12 dev ctl b3", 6'h2F, 8'h0F);
   endtask

   task automatic t_unmapped;
      logic [7:0] en_before, ctl_before, d;
      rd(6'h02, en_before);
      rd(6'h29, ctl_before);
      wr(6'h06, 8'hFF);
      wr(6'h14, 8'hFF);
      wr(6'h3F, 8'hFF);
      rd_chk("R13 read 06", 6'h06, 8'h00);
      rd_chk("R13 read 14", 6'h14, 8'h00);
      rd_chk("R13 read 3F", 6'h3F, 8'h00);
      rd(6'h02, d);
      chk("R13 pm en untouched", {24'h0, d}, {24'h0, en_before});
      rd(6'h29, d);
      chk("R13 glb ctl untouched", {24'h0, d}, {24'h0, ctl_before});
      chk("R13 no sleep pulse", {30'h0, soft_off, suspend}, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_pm_sts();
      t_pm_en();
      t_sci();
      t_sleep();
      t_timer();
      t_gp();
      t_glb();
      t_dev();
      t_unmapped();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule